// File: doc/BRIEF.md
# CPU Clock Source and Divide Controller

This block owns the processor clock control register of a small microcontroller. The register sits on a simple byte-wide register bus. From its contents, and from two flags kept elsewhere, the block picks the rate at which the CPU advances. Every clock in this design is an enable strobe, not a gated clock. The block receives several strobes: one at the main oscillator rate, one at the subclock rate, and one from the ×4 subclock multiplier. It then produces a single CPU enable strobe.

The register has two live fields: a divide select (bit 1) and a main-oscillator stop request (bit 7). When the separate subclock-select flag is low, the CPU runs from the main clock, either undivided or divided by four. When that flag is high, the divide select is ignored. The CPU then runs from the subclock divided by two, or from the multiplied subclock when the multiplier flag is set.

A stop request can only be written while the subclock drives the CPU. The request is dropped as soon as the main clock is selected again. Changes of rate are held back until a clean period boundary. The register accepts full byte writes and also single-bit writes that name a bit index and a value.

Top module: `cpuclk_ctrl`

## Requirements
- R1: After reset the register reads 0x02, `osc_stop` is 0, and the CPU runs from the main clock divided by four.
- R2: Bits 0 and 2 through 6 of `ctl_rdata` always read 0, whatever is written to them.
- R3: With `sub_sel`=0 and bit 1 = 0, `cpu_en` equals `main_tick` every cycle.
- R4: With `sub_sel`=0 and bit 1 = 1, `cpu_en` pulses on every fourth `main_tick`.
- R5: With `sub_sel`=1 and `mult_x4`=0, `cpu_en` pulses on every second `sub_tick`, and bit 1 has no effect on it.
- R6: With `sub_sel`=1 and `mult_x4`=1, `cpu_en` equals `sub_x4_tick`.
- R7: Writing 1 to bit 7 while `sub_sel`=1 sets `osc_stop` (bit 7) from the next cycle on.
- R8: Writing 1 to bit 7 while `sub_sel`=0 is discarded: bit 7 and `osc_stop` stay 0.
- R9: A single-bit write (`bus_bitop`=1) changes only the bit named by `bus_bitidx`. Indexes other than 7 and 1 change nothing.
- R10: A write whose address differs from `REG_ADDR` (default 0xFB) changes nothing.
- R11: A rate change takes effect only on a cycle where the outgoing rate's `cpu_en` pulses. A switch between the two main-clock rates waits for a divide-by-four boundary.
- R12: Whenever `sub_sel` is 0, bit 7 is cleared on the next clock, so a selected main clock is always running.
- R13: The divide-by-four and divide-by-two counters start from zero at reset. With `main_tick` high every cycle after reset, the first `cpu_en` comes on the fourth tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_bitop | input | 1 | 1: single-bit write, 0: byte write |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Byte write data |
| bus_bitidx | input | 3 | Bit index for single-bit write |
| bus_bitval | input | 1 | Value for single-bit write |
| ctl_rdata | output | 8 | Register read value |
| main_tick | input | 1 | Main oscillator enable strobe |
| sub_tick | input | 1 | Subclock enable strobe |
| sub_x4_tick | input | 1 | Multiplied subclock enable strobe |
| sub_sel | input | 1 | Subclock selected as CPU source (from another register) |
| mult_x4 | input | 1 | Subclock multiplier in use |
| cpu_en | output | 1 | CPU clock enable strobe |
| osc_stop | output | 1 | Main oscillator stop request |

## Verification
Several properties are checked on every cycle:
- the reserved bits read as zero;
- a stop request only ever follows a selected subclock, and a stop write is refused while the main clock is selected;
- a write to another address leaves the divide select alone;
- a rate switch lands only on a CPU strobe;
- in the undivided and multiplied modes the CPU strobe tracks its source tick.

Other behaviours need the bench's scenarios and its cycle reference model:
- the divide-by-four and divide-by-two pulse spacing;
- the first strobe after reset;
- the ignored divide bit under the subclock;
- single-bit writes to unused indexes;
- the wait for a quarter-rate boundary when moving between main-clock rates.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  typedef enum logic [1:0] {
    CK_MAIN_FULL = 2'd0,
    CK_MAIN_QTR  = 2'd1,
    CK_SUB_HALF  = 2'd2,
    CK_SUB_X4    = 2'd3
  } ck_mode_e;

  localparam int STOP_BIT = 7;
  localparam int DIV_BIT  = 1;
  localparam logic [7:0] CTL_RESET = 8'h02;

  // Mode requested by the current register and flag settings
  function automatic ck_mode_e pick_mode(logic sub_sel, logic x4, logic div_sel);
    if (sub_sel) return x4 ? CK_SUB_X4 : CK_SUB_HALF;
    return div_sel ? CK_MAIN_QTR : CK_MAIN_FULL;
  endfunction

  function automatic logic is_main(ck_mode_e m);
    return (m == CK_MAIN_FULL) || (m == CK_MAIN_QTR);
  endfunction

  // Register image with reserved bits forced to zero
  function automatic logic [7:0] pack_ctl(logic stop, logic div_sel);
    logic [7:0] v;
    v = 8'h00;
    v[STOP_BIT] = stop;
    v[DIV_BIT]  = div_sel;
    return v;
  endfunction

endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              bit_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  input  logic              sub_sel,
  output logic              hit,
  output logic              stop_q,
  output logic              div_q
);

  localparam logic [2:0] STOP_IDX = 3'(STOP_BIT);
  localparam logic [2:0] DIV_IDX  = 3'(DIV_BIT);

  logic stop_n, div_n;

  assign hit = wr_en && (addr == REG_ADDR);

  always_comb begin
    stop_n = stop_q;
    div_n  = div_q;
    if (hit) begin
      if (bit_op) begin
        if (bit_idx == STOP_IDX) stop_n = bit_val & sub_sel;
        if (bit_idx == DIV_IDX)  div_n  = bit_val;
      end else begin
        stop_n = wdata[STOP_BIT] & sub_sel;
        div_n  = wdata[DIV_BIT];
      end
    end
    // main clock selected: it must be running
    if (!sub_sel) stop_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= CTL_RESET[STOP_BIT];
      div_q  <= CTL_RESET[DIV_BIT];
    end else begin
      stop_q <= stop_n;
      div_q  <= div_n;
    end
  end

endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic strobe
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign strobe = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cpuclk_sel.sv
module cpuclk_sel
  import cpuclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ck_mode_e req_mode,
  input  logic     main_tick,
  input  logic     main_q_strobe,
  input  logic     sub_h_strobe,
  input  logic     x4_tick,
  output ck_mode_e act_mode,
  output logic     cpu_en,
  output logic     switch_now
);

  logic boundary;

  always_comb begin
    unique case (act_mode)
      CK_MAIN_FULL: cpu_en = main_tick;
      CK_MAIN_QTR:  cpu_en = main_q_strobe;
      CK_SUB_HALF:  cpu_en = sub_h_strobe;
      default:      cpu_en = x4_tick;
    endcase
  end

  // Between the two main rates wait for a quarter-rate edge
  assign boundary   = (is_main(act_mode) && is_main(req_mode)) ? main_q_strobe : 1'b1;
  assign switch_now = (req_mode != act_mode) && cpu_en && boundary;

  always_ff @(posedge clk) begin
    if (!rst_n)          act_mode <= CK_MAIN_QTR;
    else if (switch_now) act_mode <= req_mode;
  end

endmodule

// File: rtl/cpuclk_ctrl.sv
module cpuclk_ctrl
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hFB,
  parameter int MAIN_DIV = 4,
  parameter int SUB_DIV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_bitop,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [2:0]        bus_bitidx,
  input  logic              bus_bitval,
  output logic [7:0]        ctl_rdata,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              sub_x4_tick,
  input  logic              sub_sel,
  input  logic              mult_x4,
  output logic              cpu_en,
  output logic              osc_stop
);

  localparam int NDIV = 2;

  logic     reg_hit, stop_q, div_q, mode_switch;
  ck_mode_e req_mode, act_mode;
  logic [NDIV-1:0] div_tick, div_strobe;

  assign div_tick = {sub_tick, main_tick};

  cpuclk_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .bit_op(bus_bitop),
    .addr(bus_addr), .wdata(bus_wdata), .bit_idx(bus_bitidx),
    .bit_val(bus_bitval), .sub_sel(sub_sel), .hit(reg_hit),
    .stop_q(stop_q), .div_q(div_q)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int RATIO = (g == 0) ? MAIN_DIV : SUB_DIV;
    cpuclk_divider #(.DIV(RATIO)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(div_tick[g]), .strobe(div_strobe[g])
    );
  end

  assign req_mode = pick_mode(sub_sel, mult_x4, div_q);

  cpuclk_sel u_sel (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .main_tick(main_tick),
    .main_q_strobe(div_strobe[0]), .sub_h_strobe(div_strobe[1]),
    .x4_tick(sub_x4_tick), .act_mode(act_mode), .cpu_en(cpu_en),
    .switch_now(mode_switch)
  );

  assign ctl_rdata = pack_ctl(stop_q, div_q);
  assign osc_stop  = stop_q;

endmodule

// File: rtl/cpuclk_ctrl_chk.sv
module cpuclk_ctrl_chk
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hFB
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        ctl_rdata,
  input logic              main_tick,
  input logic              sub_x4_tick,
  input logic              sub_sel,
  input logic              cpu_en,
  input logic              osc_stop,
  input logic              reg_hit,
  input logic              mode_switch,
  input ck_mode_e          act_mode
);

  // R2
  always_comb begin
    if (rst_n) rsvd_zero_chk: assert ((ctl_rdata & 8'h7D) == 8'h00);
  end

  // R12
  stop_needs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> $past(sub_sel));

  // R8
  stop_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && !sub_sel) |=> !osc_stop);

  // R10
  miss_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_ADDR) |=> $stable(ctl_rdata[1]));

  // R11
  switch_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |-> cpu_en);

  // R3
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == CK_MAIN_FULL) |-> (cpu_en == main_tick));

  // R6
  x4_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == CK_SUB_X4) |-> (cpu_en == sub_x4_tick));

endmodule

bind cpuclk_ctrl cpuclk_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ctl_rdata(ctl_rdata), .main_tick(main_tick), .sub_x4_tick(sub_x4_tick),
  .sub_sel(sub_sel), .cpu_en(cpu_en), .osc_stop(osc_stop),
  .reg_hit(reg_hit), .mode_switch(mode_switch), .act_mode(act_mode)
);

// File: tb/test_cpuclk_ctrl.sv
module test_cpuclk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_bitop = 1'b0, bus_bitval = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [2:0] bus_bitidx = 3'd0;
  logic [7:0] ctl_rdata;
  logic       main_tick = 1'b0, sub_tick = 1'b0, sub_x4_tick = 1'b0;
  logic       sub_sel = 1'b0, mult_x4 = 1'b0;
  logic       cpu_en, osc_stop;

  int vectors = 0, errors = 0;
  bit done = 0;
  bit auto_ticks = 1;

  // reference state: mode 0 full, 1 quarter, 2 sub half, 3 sub x4
  int m_cnt, s_cnt, r_mode;
  bit r_stop, r_div;

  always #10 clk = ~clk;

  cpuclk_ctrl i_cpuclk_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bitop(bus_bitop),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_bitidx(bus_bitidx),
    .bus_bitval(bus_bitval), .ctl_rdata(ctl_rdata), .main_tick(main_tick),
    .sub_tick(sub_tick), .sub_x4_tick(sub_x4_tick), .sub_sel(sub_sel),
    .mult_x4(mult_x4), .cpu_en(cpu_en), .osc_stop(osc_stop)
  );

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_strobe(int mode);
    case (mode)
      0: return main_tick;
      1: return main_tick && (m_cnt == 3);
      2: return sub_tick && (s_cnt == 1);
      default: return sub_x4_tick;
    endcase
  endfunction

  // one clock: compare before the edge, then advance the model
  task automatic step(string tag);
    int want, n_mode;
    bit en, q_edge, n_stop, n_div;
    if (auto_ticks) begin
      main_tick   = ($urandom_range(0, 1) == 1);
      sub_tick    = ($urandom_range(0, 4) == 0);
      sub_x4_tick = ($urandom_range(0, 2) == 0);
    end
    #5;
    en = exp_strobe(r_mode);
    check(tag, "cpu_en", int'(cpu_en), int'(en));
    check(tag, "osc_stop", int'(osc_stop), int'(r_stop));
    check(tag, "rdata", int'(ctl_rdata), (int'(r_stop) << 7) | (int'(r_div) << 1));
    n_stop = r_stop; n_div = r_div;
    if (bus_wr && bus_addr == 8'hFB) begin
      if (bus_bitop) begin
        if (bus_bitidx == 3'd7) n_stop = bus_bitval && sub_sel;
        if (bus_bitidx == 3'd1) n_div = bus_bitval;
      end else begin
        n_stop = bus_wdata[7] && sub_sel;
        n_div = bus_wdata[1];
      end
    end
    if (!sub_sel) n_stop = 0;
    want = sub_sel ? (mult_x4 ? 3 : 2) : (r_div ? 1 : 0);
    q_edge = main_tick && (m_cnt == 3);
    n_mode = r_mode;
    if (want != r_mode && en && ((r_mode < 2 && want < 2) ? q_edge : 1'b1)) n_mode = want;
    @(posedge clk);
    if (main_tick) m_cnt = (m_cnt + 1) % 4;
    if (sub_tick) s_cnt = (s_cnt + 1) % 2;
    r_stop = n_stop; r_div = n_div; r_mode = n_mode;
    @(negedge clk);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr_byte(logic [7:0] a, logic [7:0] d, string tag);
    bus_wr = 1; bus_bitop = 0; bus_addr = a; bus_wdata = d;
    step(tag);
    bus_wr = 0;
  endtask

  task automatic wr_bit(logic [2:0] idx, logic v, string tag);
    bus_wr = 1; bus_bitop = 1; bus_addr = 8'hFB; bus_bitidx = idx; bus_bitval = v;
    step(tag);
    bus_wr = 0; bus_bitop = 0;
  endtask

  initial begin
    m_cnt = 0; s_cnt = 0; r_mode = 1; r_stop = 0; r_div = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13: first quarter strobe on the fourth main tick
    auto_ticks = 0; main_tick = 1; sub_tick = 0; sub_x4_tick = 0;
    run("R13", 6);
    auto_ticks = 1;
    run("R1", 40);
    run("R4", 60);
    wr_byte(8'hFB, 8'h00, "R3");
    run("R3", 60);
    wr_byte(8'hFB, 8'hFF, "R8");
    run("R2", 20);
    wr_byte(8'h7B, 8'h00, "R10");
    run("R10", 20);
    wr_bit(3'd1, 1'b0, "R9");
    wr_bit(3'd4, 1'b1, "R9");
    wr_bit(3'd0, 1'b1, "R9");
    run("R9", 30);
    // R11: main rate changes with every-cycle main ticks
    auto_ticks = 0; main_tick = 1;
    wr_byte(8'hFB, 8'h02, "R11");
    run("R11", 12);
    wr_bit(3'd1, 1'b0, "R11");
    run("R11", 12);
    wr_bit(3'd1, 1'b1, "R11");
    run("R11", 12);
    auto_ticks = 1;
    sub_sel = 1;
    run("R5", 60);
    wr_bit(3'd1, 1'b0, "R5");
    run("R5", 60);
    wr_bit(3'd7, 1'b1, "R7");
    run("R7", 20);
    mult_x4 = 1;
    run("R6", 60);
    wr_byte(8'hFB, 8'h00, "R7");
    wr_byte(8'hFB, 8'h82, "R7");
    run("R7", 10);
    sub_sel = 0; mult_x4 = 0;
    run("R12", 40);
    wr_bit(3'd7, 1'b1, "R8");
    run("R8", 40);
    rst_n = 0;
    step("R1");
    m_cnt = 0; s_cnt = 0; r_mode = 1; r_stop = 0; r_div = 1;
    rst_n = 1;
    run("R1", 30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule